// File: doc/BRIEF.md
# Multi-Stage UAV Coherency Tracker

This block keeps the books for unordered-access memory traffic in a five-stage fixed-function shader pipeline, ordered vertex, hull, domain, geometry, pixel (stage index 0 to 4). Each stage has a static "uses UAV" enable bit. The block holds one saturating semaphore per stage. A stage's semaphore counts a received request when that stage or any later stage is enabled. When the last enabled stage finishes a request, the block queues one data-cache flush. Each acknowledged flush releases the semaphores of that stage and of every stage before it.

A new primitive may carry a "coherency required" flag. When it does, the block holds off thread dispatch at the first enabled stage until that stage's semaphore has drained to zero. The enables are written through a configuration strobe. The block accepts a write only while every semaphore is zero. Three sticky error flags record counter overflow, counter underflow and rejected configuration writes.

The flush request is a valid/ready stream with no payload. `flush_valid_o` stays high while at least one flush is queued. A flush counts as delivered only in a cycle where `flush_ready_i` is also high. While ready is low the request is held, so the consumer applies back-pressure just by leaving ready low. All other pins are plain single-cycle pulses or levels.

Top module: `uot_order_tracker`

## Requirements
- R1: A synchronous active-high reset clears all semaphores, the flush queue, the enables, the stall outputs and the three error flags.
- R2: A pulse on `req_rcv_i[i]` adds one to semaphore i if enable bit j is set for some j >= i. Otherwise it has no effect. The coherency flag plays no part in this.
- R3: A pulse on `req_done_i[i]` queues one flush only when i is the highest-numbered enabled stage. Done pulses from other stages are ignored.
- R4: `flush_valid_o` is high exactly while the queue is non-empty. It stays high without change while `flush_ready_i` is low. Each cycle with both valid and ready high removes one queued flush.
- R5: Each flush handshake subtracts one from semaphore i for every i at or below the highest-numbered enabled stage.
- R6: After a primitive strobe with the coherency flag set, `stall_o` has only the bit of the lowest-numbered enabled stage high, and only while that stage's semaphore is nonzero. The stall clears once the semaphore reaches zero. A primitive strobe without the flag causes no stall.
- R7: With no enable set, semaphores never change and `flush_valid_o` never rises.
- R8: A semaphore at its maximum value (2^CNT_W - 1) holds that value on a further increment and sets `err_ovf_o`.
- R9: A decrement of a semaphore at zero leaves it at zero and sets `err_unf_o`.
- R10: A configuration write is applied only when all semaphores are zero. Otherwise the write is ignored, the old enables stay in force, and `err_cfg_o` is set.
- R11: An increment and a decrement of the same semaphore in one cycle leave it unchanged.
- R12: The error flags are sticky until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | NUM_STAGES | Requested per-stage UAV enables (bit 0 = vertex) |
| req_rcv_i | input | NUM_STAGES | Per-stage request-received pulses |
| req_done_i | input | NUM_STAGES | Per-stage request-finished pulses |
| prim_valid_i | input | 1 | New primitive strobe |
| prim_coh_i | input | 1 | Coherency-required flag of that primitive |
| flush_valid_o | output | 1 | Flush request valid |
| flush_ready_i | input | 1 | Flush complete / accept |
| stall_o | output | NUM_STAGES | Per-stage dispatch stall |
| sem_level_o | output | NUM_STAGES*CNT_W | Semaphore levels, stage i at bits i*CNT_W upward |
| err_ovf_o | output | 1 | Sticky semaphore or queue overflow |
| err_unf_o | output | 1 | Sticky semaphore underflow |
| err_cfg_o | output | 1 | Sticky rejected configuration write |

## Verification
The bench builds the block with CNT_W = 4 and PEND_W = 4. With these widths a semaphore saturates after fifteen requests, so the overflow path is reached in a few cycles. The stage count stays at five, which keeps the sweep over all 32 enable masks cheap. For each mask the sweep works out the charged stages, the flushing stage and the released prefix arithmetically, then checks receive, done, back-pressure and release. Directed runs then cover stalling, overlap of increment and release, underflow and rejected writes.

// File: rtl/uot_pkg.sv
package uot_pkg;
  localparam int unsigned STAGES_DEFAULT = 5;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/uot_stage_mask.sv
module uot_stage_mask #(
  parameter int unsigned NUM_STAGES = 5
) (
  input  logic [NUM_STAGES-1:0] en_i,
  output logic [NUM_STAGES-1:0] reach_o,
  output logic [NUM_STAGES-1:0] first_oh_o,
  output logic [NUM_STAGES-1:0] last_oh_o
);
  logic [NUM_STAGES-1:0] below;

  generate
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_mask
      if (i == NUM_STAGES - 1) begin : g_top
        assign reach_o[i]   = en_i[i];
        assign last_oh_o[i] = en_i[i];
      end else begin : g_mid
        assign reach_o[i]   = en_i[i] | reach_o[i+1];
        assign last_oh_o[i] = en_i[i] & ~reach_o[i+1];
      end
      if (i == 0) begin : g_bot
        assign below[i] = 1'b0;
      end else begin : g_up
        assign below[i] = below[i-1] | en_i[i-1];
      end
      assign first_oh_o[i] = en_i[i] & ~below[i];
    end
  endgenerate
endmodule

// File: rtl/uot_sem_counter.sv
module uot_sem_counter
  import uot_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] level_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};
  cnt_op_e op;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    op = CNT_HOLD;
    if (inc_i && !dec_i) op = CNT_UP;
    else if (dec_i && !inc_i) op = CNT_DOWN;
  end

  assign ovf_o = (op == CNT_UP) && (cnt_q == MAX_V);
  assign unf_o = (op == CNT_DOWN) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (op == CNT_UP && !ovf_o) cnt_q <= cnt_q + 1'b1;
    else if (op == CNT_DOWN && !unf_o) cnt_q <= cnt_q - 1'b1;
  end

  assign level_o = cnt_q;
endmodule

// File: rtl/uot_flush_queue.sv
module uot_flush_queue #(
  parameter int unsigned PEND_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic push_i,
  input  logic ready_i,
  output logic valid_o,
  output logic fire_o,
  output logic ovf_o
);
  localparam logic [PEND_W-1:0] MAX_P = {PEND_W{1'b1}};
  logic [PEND_W-1:0] pend_q;

  assign valid_o = (pend_q != '0);
  assign fire_o  = valid_o && ready_i;
  assign ovf_o   = push_i && !fire_o && (pend_q == MAX_P);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else if (push_i && !fire_o && !ovf_o) pend_q <= pend_q + 1'b1;
    else if (fire_o && !push_i) pend_q <= pend_q - 1'b1;
  end
endmodule

// File: rtl/uot_order_tracker.sv
module uot_order_tracker #(
  parameter int unsigned NUM_STAGES = 5,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PEND_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_wr_i,
  input  logic [NUM_STAGES-1:0]       cfg_en_i,
  input  logic [NUM_STAGES-1:0]       req_rcv_i,
  input  logic [NUM_STAGES-1:0]       req_done_i,
  input  logic                        prim_valid_i,
  input  logic                        prim_coh_i,
  output logic                        flush_valid_o,
  input  logic                        flush_ready_i,
  output logic [NUM_STAGES-1:0]       stall_o,
  output logic [NUM_STAGES*CNT_W-1:0] sem_level_o,
  output logic                        err_ovf_o,
  output logic                        err_unf_o,
  output logic                        err_cfg_o
);
  logic [NUM_STAGES-1:0] en_q;
  logic [NUM_STAGES-1:0] reach, first_oh, last_oh;
  logic [NUM_STAGES-1:0] s_ovf, s_unf;
  logic                  fire, q_ovf, done_hit, all_zero, coh_q;
  logic [CNT_W-1:0]      first_lvl;

  uot_stage_mask #(.NUM_STAGES(NUM_STAGES)) u_mask (
    .en_i(en_q), .reach_o(reach), .first_oh_o(first_oh), .last_oh_o(last_oh)
  );

  generate
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_sem
      uot_sem_counter #(.CNT_W(CNT_W)) u_sem (
        .clk(clk), .rst(rst),
        .inc_i(req_rcv_i[i] & reach[i]),
        .dec_i(fire & reach[i]),
        .level_o(sem_level_o[i*CNT_W +: CNT_W]),
        .ovf_o(s_ovf[i]), .unf_o(s_unf[i])
      );
    end
  endgenerate

  assign done_hit = |(req_done_i & last_oh);

  uot_flush_queue #(.PEND_W(PEND_W)) u_fq (
    .clk(clk), .rst(rst), .push_i(done_hit), .ready_i(flush_ready_i),
    .valid_o(flush_valid_o), .fire_o(fire), .ovf_o(q_ovf)
  );

  always_comb begin
    all_zero  = (sem_level_o == '0);
    first_lvl = '0;
    for (int i = 0; i < NUM_STAGES; i++)
      first_lvl = first_lvl | (sem_level_o[i*CNT_W +: CNT_W] & {CNT_W{first_oh[i]}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      coh_q     <= 1'b0;
      err_ovf_o <= 1'b0;
      err_unf_o <= 1'b0;
      err_cfg_o <= 1'b0;
    end else begin
      if (cfg_wr_i) begin
        if (all_zero) en_q <= cfg_en_i;
        else err_cfg_o <= 1'b1;
      end
      if (prim_valid_i) coh_q <= prim_coh_i;
      else if (first_lvl == '0) coh_q <= 1'b0;
      if (|s_ovf || q_ovf) err_ovf_o <= 1'b1;
      if (|s_unf) err_unf_o <= 1'b1;
    end
  end

  assign stall_o = first_oh & {NUM_STAGES{coh_q && (first_lvl != '0)}};
endmodule

// File: rtl/uot_checker.sv
module uot_checker #(
  parameter int unsigned NUM_STAGES = 5,
  parameter int unsigned CNT_W      = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cfg_wr_i,
  input logic [NUM_STAGES-1:0]       en_q,
  input logic                        flush_valid_o,
  input logic                        flush_ready_i,
  input logic [NUM_STAGES-1:0]       stall_o,
  input logic [NUM_STAGES*CNT_W-1:0] sem_level_o,
  input logic                        err_ovf_o,
  input logic                        err_unf_o,
  input logic                        err_cfg_o
);
  // R4
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    flush_valid_o && !flush_ready_i |=> flush_valid_o);

  // R6
  stall_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stall_o));

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> $stable(sem_level_o));

  // R10
  cfg_reject_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_i && (sem_level_o != '0) |=> err_cfg_o);

  // R12
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    (err_ovf_o || err_unf_o) |=> (err_ovf_o || err_unf_o));
endmodule

bind uot_order_tracker uot_checker #(.NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr_i), .en_q(en_q),
  .flush_valid_o(flush_valid_o), .flush_ready_i(flush_ready_i),
  .stall_o(stall_o), .sem_level_o(sem_level_o),
  .err_ovf_o(err_ovf_o), .err_unf_o(err_unf_o), .err_cfg_o(err_cfg_o)
);

// File: tb/sim_uot_order_tracker.sv
module sim_uot_order_tracker;
  localparam int S = 5;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, prim_v = 0, prim_c = 0, fready = 0;
  logic [S-1:0] cfg_en = '0, rcv = '0, done = '0;
  logic fvalid, eovf, eunf, ecfg;
  logic [S-1:0] stall;
  logic [S*W-1:0] lvl;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uot_order_tracker #(.NUM_STAGES(S), .CNT_W(W), .PEND_W(4)) u0 (
    .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr), .cfg_en_i(cfg_en),
    .req_rcv_i(rcv), .req_done_i(done), .prim_valid_i(prim_v), .prim_coh_i(prim_c),
    .flush_valid_o(fvalid), .flush_ready_i(fready), .stall_o(stall),
    .sem_level_o(lvl), .err_ovf_o(eovf), .err_unf_o(eunf), .err_cfg_o(ecfg)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int reach(input int m, input int i);
    return ((m >> i) != 0) ? 1 : 0;
  endfunction

  function automatic int sem(input int i);
    return int'(lvl[i*W +: W]);
  endfunction

  task automatic tick();
    @(negedge clk);
    cfg_wr = 0; rcv = '0; done = '0; prim_v = 0; prim_c = 0; fready = 0;
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic set_cfg(input int m);
    cfg_en = S'(m); cfg_wr = 1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick();
    do_reset();
    // R1 reset state
    chk("R1 levels", int'(lvl), 0);
    chk("R1 valid", int'(fvalid), 0);
    chk("R1 stall", int'(stall), 0);
    chk("R1 errs", int'({eovf, eunf, ecfg}), 0);

    // Sweep all enable masks: R2 R3 R4 R5 R7
    for (int m = 0; m < 32; m++) begin
      set_cfg(m);
      rcv = '1; tick();
      for (int i = 0; i < S; i++) chk("R2 charge", sem(i), reach(m, i));
      done = '1; tick();
      chk("R3 R7 queued", int'(fvalid), (m != 0) ? 1 : 0);
      tick();
      chk("R4 hold", int'(fvalid), (m != 0) ? 1 : 0);
      fready = 1; tick();
      chk("R4 drained", int'(fvalid), 0);
      for (int i = 0; i < S; i++) chk("R5 release", sem(i), 0);
      // done at a non-last stage is ignored
      if (m != 0 && m != 1) begin
        done = 5'b00001; tick();
        chk("R3 ignore", int'(fvalid), (m == 1) ? 1 : 0);
      end
    end
    chk("R12 no err", int'({eovf, eunf, ecfg}), 0);

    // R6 stall at first enabled stage (stage 1), last = 2
    do_reset();
    set_cfg(5'b00110);
    prim_v = 1; prim_c = 0; tick();
    chk("R6 no flag", int'(stall), 0);
    rcv = 5'b00010; tick();
    chk("R6 no flag busy", int'(stall), 0);
    prim_v = 1; prim_c = 1; tick();
    chk("R6 stall", int'(stall), 2);
    done = 5'b00100; tick();
    chk("R6 still", int'(stall), 2);
    // R11 receive and release same cycle on stage 1
    rcv = 5'b00010; fready = 1; tick();
    chk("R11 same", sem(1), 1);
    done = 5'b00100; tick();
    fready = 1; tick();
    chk("R6 released", int'(stall), 0);
    chk("R5 zero", sem(1), 0);

    // R8 saturation
    do_reset();
    set_cfg(5'b00001);
    for (int k = 0; k < 15; k++) begin rcv = 5'b00001; tick(); end
    chk("R8 max", sem(0), 15);
    chk("R8 no flag yet", int'(eovf), 0);
    rcv = 5'b00001; tick();
    chk("R8 hold", sem(0), 15);
    chk("R8 flag", int'(eovf), 1);
    tick();
    chk("R12 sticky", int'(eovf), 1);

    // R9 underflow
    do_reset();
    set_cfg(5'b00001);
    done = 5'b00001; tick();
    fready = 1; tick();
    chk("R9 level", sem(0), 0);
    chk("R9 flag", int'(eunf), 1);

    // R10 rejected write
    do_reset();
    set_cfg(5'b00001);
    rcv = 5'b00001; tick();
    set_cfg(5'b00010);
    chk("R10 flag", int'(ecfg), 1);
    rcv = 5'b00010; tick();
    chk("R10 old mask", sem(1), 0);
    chk("R10 old mask s0", sem(0), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule